// File: doc/BRIEF.md
# Predicated Element Sequencer with Fail-First

This block walks one vector operation through its elements in strict order, element 0 first, up to a vector length given at start. For each element it chooses to issue it to an execution unit, to write zero to its destination, or to skip it with no strobe. The choice comes from a 64-bit integer mask, a mask-invert bit, a "no masking" selector and a 5-bit mode value. Issued elements return a feedback beat carrying a 4-bit condition field and a memory-exception flag. From that beat the block decides whether the data result and the condition field are committed.

Two data-dependent modes use the feedback. In condition fail-first, a failed test on one element discards it and all later elements, and the run ends with the vector length cut to the number of elements before it. In predicate-result mode, a failed test keeps the condition write-back but masks the data write. For memory operations in fail-first mode, an exception on element 0 traps as usual. An exception on a later element only shortens the vector length. A single-cycle done pulse carries the final vector length.

Top module: `pred_elem_seq`

## Requirements
- R1: After reset, busy, issue, zero_wr, commit, cr_wr, done and trap are 0 and final_vl is 0.
- R2: Within one run, the strobes issue and zero_wr carry strictly increasing elem_idx values that start from the lowest element considered, in order from element 0.
- R3: An element whose effective predicate bit is 0 is skipped, with no issue and no zero_wr, unless zeroing is on. The effective bit is pred_mask[i] XOR pred_inv.
- R4: Zeroing is on when mode[4:3]=00, mode[2]=1 and mode[0]=1. A masked-out element then raises zero_wr instead of issue, and never both in one cycle.
- R5: pred_all=1 (no masking) makes every element active, whatever pred_mask and pred_inv hold.
- R6: The condition test passes when fb_cond[mode[1:0]] XOR mode[2] is 1.
- R7: With mode[4:3]=01, rc=1 and is_ldst=0, a failed test on element i gives no commit and no cr_wr for i and issues no later element. The run ends with final_vl=i.
- R8: With mode[4:3]=01 and is_ldst=1, fb_exc on element 0 ends the run with trap=1 and final_vl equal to the start VL. fb_exc on element i>0 ends it with trap=0 and final_vl=i, and element i is not committed.
- R9: With mode[4:3]=11 and rc=1, a failed test gives cr_wr=1 with commit=0, and a passing test gives both. Mode 10 and mode 00 without zeroing behave as plain predication.
- R10: done is a one-cycle pulse. final_vl is valid in that cycle and equals the start VL when no truncation happens. Outside fail-first, cr_wr accompanies each commit when rc=1.
- R11: A start with VL=0 issues nothing and raises done with final_vl=0 in the second cycle after the start cycle.
- R12: fb_exc outside memory fail-first ends the run with trap=1 and final_vl equal to the start VL.
- R13: start is ignored while busy=1. A VL above 64 is taken as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken when idle) |
| vl_in | input | 7 | Vector length for the run, clamped to 64 |
| pred_mask | input | 64 | Integer predicate, bit i for element i |
| pred_all | input | 1 | No-masking selector: all elements active |
| pred_inv | input | 1 | Invert the predicate mask |
| mode | input | 5 | Mode: [4:3] class, [2] invert or zero enable, [1:0] condition bit select |
| rc | input | 1 | Operation writes a condition field |
| is_ldst | input | 1 | Operation is a load or store |
| fb_valid | input | 1 | Feedback beat for the issued element |
| fb_cond | input | 4 | Condition field of the issued element |
| fb_exc | input | 1 | Memory exception on the issued element |
| busy | output | 1 | Run in progress |
| issue | output | 1 | Issue element elem_idx |
| zero_wr | output | 1 | Write zero to element elem_idx |
| commit | output | 1 | Data result of elem_idx may be written |
| cr_wr | output | 1 | Condition field of elem_idx may be written |
| elem_idx | output | 6 | Current element index |
| done | output | 1 | Run finished (one cycle) |
| trap | output | 1 | Run ended by a normal exception |
| final_vl | output | 7 | Resulting vector length, valid with done |

## Verification
Every output is registered. issue or zero_wr for an element appears one cycle after the sequencer reaches that element. commit and cr_wr appear one cycle after the edge that samples the feedback beat, and done follows one cycle after the sequencer steps past the last element or sees a failing beat. The bench samples on the falling edge and answers each issue strobe at that same falling edge, so the feedback is taken at the next rising edge. It builds bit masks of the strobes and compares them with hand-derived masks once done is seen. The VL=0 case checks done exactly at the second falling edge after the start cycle, and every run checks that done is low one cycle later.

// File: rtl/pes_pkg.sv
package pes_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic       zero_en;  // masked-out elements write zero
    logic       cff_en;   // condition-driven fail-first
    logic       lff_en;   // memory exception fail-first
    logic       pres_en;  // predicate-result masking
    logic       cr_en;    // condition field written back
    logic       tst_inv;  // invert tested bit
    logic [1:0] tst_sel;  // tested bit position
  } mode_cfg_t;

  localparam int CONDW = 4;

endpackage

// File: rtl/pes_mode_dec.sv
module pes_mode_dec
  import pes_pkg::*;
(
  input  logic [4:0] mode,
  input  logic       rc,
  input  logic       is_ldst,
  output mode_cfg_t  cfg
);

  logic [1:0] cls;

  always_comb begin
    cls         = mode[4:3];
    cfg.zero_en = (cls == 2'b00) && mode[2] && mode[0];
    cfg.cff_en  = (cls == 2'b01) && rc && !is_ldst;
    cfg.lff_en  = (cls == 2'b01) && is_ldst;
    cfg.pres_en = (cls == 2'b11) && rc;
    cfg.cr_en   = rc;
    cfg.tst_inv = mode[2];
    cfg.tst_sel = mode[1:0];
  end

endmodule

// File: rtl/pes_pred_pick.sv
module pes_pred_pick #(
  parameter int MAXVL = 64,
  localparam int IDXW = $clog2(MAXVL)
) (
  input  logic [MAXVL-1:0] mask,
  input  logic             all_on,
  input  logic             inv,
  input  logic [IDXW-1:0]  idx,
  output logic             active
);

  logic [MAXVL-1:0] eff;

  genvar g;
  generate
    for (g = 0; g < MAXVL; g++) begin : g_bit
      assign eff[g] = all_on | (mask[g] ^ inv);
    end
  endgenerate

  assign active = eff[idx];

endmodule

// File: rtl/pes_cond_chk.sv
module pes_cond_chk
  import pes_pkg::*;
(
  input  logic [CONDW-1:0] cond,
  input  logic [1:0]       sel,
  input  logic             inv,
  output logic             pass
);

  assign pass = cond[sel] ^ inv;

endmodule

// File: rtl/pred_elem_seq.sv
module pred_elem_seq
  import pes_pkg::*;
#(
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IDXW = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VLW-1:0]   vl_in,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic             pred_all,
  input  logic             pred_inv,
  input  logic [4:0]       mode,
  input  logic             rc,
  input  logic             is_ldst,
  input  logic             fb_valid,
  input  logic [3:0]       fb_cond,
  input  logic             fb_exc,
  output logic             busy,
  output logic             issue,
  output logic             zero_wr,
  output logic             commit,
  output logic             cr_wr,
  output logic [IDXW-1:0]  elem_idx,
  output logic             done,
  output logic             trap,
  output logic [VLW-1:0]   final_vl
);

  localparam logic [VLW-1:0] VL_CAP = VLW'(MAXVL);

  seq_st_e          st_q;
  logic [VLW-1:0]   vl_q;
  logic [VLW-1:0]   idx_q;
  logic [MAXVL-1:0] mask_q;
  logic             all_q;
  logic             inv_q;
  mode_cfg_t        cfg_q;
  mode_cfg_t        cfg_d;
  logic             act;
  logic             pass;
  logic [VLW-1:0]   vl_clamp;
  logic             at_end;

  pes_mode_dec u_dec (
    .mode    (mode),
    .rc      (rc),
    .is_ldst (is_ldst),
    .cfg     (cfg_d)
  );

  pes_pred_pick #(.MAXVL(MAXVL)) u_pick (
    .mask   (mask_q),
    .all_on (all_q),
    .inv    (inv_q),
    .idx    (idx_q[IDXW-1:0]),
    .active (act)
  );

  pes_cond_chk u_tst (
    .cond (fb_cond),
    .sel  (cfg_q.tst_sel),
    .inv  (cfg_q.tst_inv),
    .pass (pass)
  );

  assign vl_clamp = (vl_in > VL_CAP) ? VL_CAP : vl_in;
  assign at_end   = (idx_q >= vl_q);
  assign busy     = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      vl_q     <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
      all_q    <= 1'b0;
      inv_q    <= 1'b0;
      cfg_q    <= '0;
      issue    <= 1'b0;
      zero_wr  <= 1'b0;
      commit   <= 1'b0;
      cr_wr    <= 1'b0;
      elem_idx <= '0;
      done     <= 1'b0;
      trap     <= 1'b0;
      final_vl <= '0;
    end else begin
      issue   <= 1'b0;
      zero_wr <= 1'b0;
      commit  <= 1'b0;
      cr_wr   <= 1'b0;
      done    <= 1'b0;
      trap    <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            vl_q   <= vl_clamp;
            idx_q  <= '0;
            mask_q <= pred_mask;
            all_q  <= pred_all;
            inv_q  <= pred_inv;
            cfg_q  <= cfg_d;
            st_q   <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (at_end) begin
            done     <= 1'b1;
            final_vl <= vl_q;
            st_q     <= ST_IDLE;
          end else if (act) begin
            issue    <= 1'b1;
            elem_idx <= idx_q[IDXW-1:0];
            st_q     <= ST_WAIT;
          end else begin
            if (cfg_q.zero_en) begin
              zero_wr  <= 1'b1;
              elem_idx <= idx_q[IDXW-1:0];
            end
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (fb_valid) begin
            if (fb_exc) begin
              done <= 1'b1;
              st_q <= ST_IDLE;
              if (cfg_q.lff_en && (idx_q != '0)) begin
                final_vl <= idx_q;
              end else begin
                trap     <= 1'b1;
                final_vl <= vl_q;
              end
            end else if (cfg_q.cff_en && !pass) begin
              done     <= 1'b1;
              final_vl <= idx_q;
              st_q     <= ST_IDLE;
            end else begin
              commit <= !(cfg_q.pres_en && !pass);
              cr_wr  <= cfg_q.cr_en;
              idx_q  <= idx_q + 1'b1;
              st_q   <= ST_STEP;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pes_chk.sv
module pes_chk #(
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IDXW = $clog2(MAXVL)
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [VLW-1:0]  vl_in,
  input logic            busy,
  input logic            issue,
  input logic            zero_wr,
  input logic            commit,
  input logic            cr_wr,
  input logic [IDXW-1:0] elem_idx,
  input logic            done,
  input logic            trap,
  input logic [VLW-1:0]  final_vl
);

  localparam logic [VLW-1:0] VL_CAP = VLW'(MAXVL);

  logic [VLW-1:0]  vl_c;
  logic [IDXW-1:0] last_idx;
  logic            seen;
  logic            pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_c     <= '0;
      last_idx <= '0;
      seen     <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (start && !busy) begin
        vl_c <= (vl_in > VL_CAP) ? VL_CAP : vl_in;
        seen <= 1'b0;
      end else if (issue || zero_wr) begin
        seen     <= 1'b1;
        last_idx <= elem_idx;
      end
      if (issue) pending <= 1'b1;
      else if (commit || cr_wr || done) pending <= 1'b0;
    end
  end

  AST_IDX_RISING: assert property (@(posedge clk) disable iff (rst)
    ((issue || zero_wr) && seen) |-> (elem_idx > last_idx)); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({issue, zero_wr, done})); // R4

  AST_WRITE_PENDING: assert property (@(posedge clk) disable iff (rst)
    (commit || cr_wr) |-> pending); // R9

  AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    trap |-> done); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_FINAL_BOUND: assert property (@(posedge clk) disable iff (rst)
    done |-> (final_vl <= vl_c)); // R7

  AST_EMPTY_RUN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (vl_in == '0)) |-> ##2 (done && (final_vl == '0))); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(issue || zero_wr)); // R13

endmodule

bind pred_elem_seq pes_chk #(.MAXVL(MAXVL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .vl_in    (vl_in),
  .busy     (busy),
  .issue    (issue),
  .zero_wr  (zero_wr),
  .commit   (commit),
  .cr_wr    (cr_wr),
  .elem_idx (elem_idx),
  .done     (done),
  .trap     (trap),
  .final_vl (final_vl)
);

// File: tb/pred_elem_seq_tb.sv
module pred_elem_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  typedef struct packed {
    logic [6:0]  vl;
    logic [7:0]  mask;
    logic        all;
    logic        inv;
    logic [4:0]  mode;
    logic        rc;
    logic        ldst;
    logic [31:0] conds;
    logic [7:0]  exc;
    logic [7:0]  e_iss;
    logic [7:0]  e_zero;
    logic [7:0]  e_com;
    logic [7:0]  e_cr;
    logic [6:0]  e_vl;
    logic        e_trap;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R3 plain mask, rc=1 -> cr_wr with commit (R10)
    '{7'd5, 8'hB5, 1'b0, 1'b0, 5'b00000, 1'b1, 1'b0, 32'h0, 8'h00, 8'h15, 8'h00, 8'h15, 8'h15, 7'd5, 1'b0, 4'd3},
    // R3 inverted mask
    '{7'd5, 8'hB5, 1'b0, 1'b1, 5'b00000, 1'b0, 1'b0, 32'h0, 8'h00, 8'h0A, 8'h00, 8'h0A, 8'h00, 7'd5, 1'b0, 4'd3},
    // R5 no masking
    '{7'd4, 8'h00, 1'b1, 1'b1, 5'b00000, 1'b0, 1'b0, 32'h0, 8'h00, 8'h0F, 8'h00, 8'h0F, 8'h00, 7'd4, 1'b0, 4'd5},
    // R4 zeroing on
    '{7'd6, 8'h26, 1'b0, 1'b0, 5'b00101, 1'b0, 1'b0, 32'h0, 8'h00, 8'h26, 8'h19, 8'h26, 8'h00, 7'd6, 1'b0, 4'd4},
    // R3 zeroing bit clear -> skip
    '{7'd6, 8'h26, 1'b0, 1'b0, 5'b00100, 1'b0, 1'b0, 32'h0, 8'h00, 8'h26, 8'h00, 8'h26, 8'h00, 7'd6, 1'b0, 4'd3},
    // R7 fail-first, bit 2 tested, fails at element 3
    '{7'd8, 8'h00, 1'b1, 1'b0, 5'b01010, 1'b1, 1'b0, 32'h0000_0444, 8'h00, 8'h0F, 8'h00, 8'h07, 8'h07, 7'd3, 1'b0, 4'd7},
    // R6 inverted test, fails at element 2
    '{7'd4, 8'h00, 1'b1, 1'b0, 5'b01100, 1'b1, 1'b0, 32'h0000_0100, 8'h00, 8'h07, 8'h00, 8'h03, 8'h03, 7'd2, 1'b0, 4'd6},
    // R7 fails at element 0 -> VL 0
    '{7'd3, 8'h00, 1'b1, 1'b0, 5'b01000, 1'b1, 1'b0, 32'h0, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 7'd0, 1'b0, 4'd7},
    // R7 rc=0 -> no truncation
    '{7'd3, 8'h00, 1'b1, 1'b0, 5'b01000, 1'b0, 1'b0, 32'h0, 8'h00, 8'h07, 8'h00, 8'h07, 8'h00, 7'd3, 1'b0, 4'd7},
    // R9 predicate-result, bit 1 tested
    '{7'd4, 8'h00, 1'b1, 1'b0, 5'b11001, 1'b1, 1'b0, 32'h0000_0202, 8'h00, 8'h0F, 8'h00, 8'h05, 8'h0F, 7'd4, 1'b0, 4'd9},
    // R9 predicate-result with mask
    '{7'd4, 8'h06, 1'b0, 1'b0, 5'b11001, 1'b1, 1'b0, 32'h0000_0202, 8'h00, 8'h06, 8'h00, 8'h04, 8'h06, 7'd4, 1'b0, 4'd9},
    // R8 memory fail-first, exception on element 3
    '{7'd6, 8'h00, 1'b1, 1'b0, 5'b01000, 1'b0, 1'b1, 32'h0, 8'h08, 8'h0F, 8'h00, 8'h07, 8'h00, 7'd3, 1'b0, 4'd8},
    // R8 memory fail-first, exception on element 0 -> trap
    '{7'd6, 8'h00, 1'b1, 1'b0, 5'b01000, 1'b0, 1'b1, 32'h0, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 7'd6, 1'b1, 4'd8},
    // R12 exception outside fail-first
    '{7'd5, 8'h00, 1'b1, 1'b0, 5'b00000, 1'b0, 1'b1, 32'h0, 8'h04, 8'h07, 8'h00, 8'h03, 8'h00, 7'd5, 1'b1, 4'd12},
    // R11 empty vector
    '{7'd0, 8'hFF, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0, 32'h0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 7'd0, 1'b0, 4'd11},
    // R9 saturation class acts as plain predication
    '{7'd3, 8'h05, 1'b0, 1'b0, 5'b10100, 1'b0, 1'b0, 32'h0, 8'h00, 8'h05, 8'h00, 8'h05, 8'h00, 7'd3, 1'b0, 4'd9}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [6:0]  vl_in;
  logic [63:0] pred_mask;
  logic        pred_all;
  logic        pred_inv;
  logic [4:0]  mode;
  logic        rc;
  logic        is_ldst;
  logic        fb_valid;
  logic [3:0]  fb_cond;
  logic        fb_exc;
  logic        busy, issue, zero_wr, commit, cr_wr, done, trap;
  logic [5:0]  elem_idx;
  logic [6:0]  final_vl;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [7:0] got_iss, got_zero, got_com, got_cr;
  logic [6:0] got_vl;
  logic       got_trap;
  int         iss_cnt;
  int         last_iss;
  logic [31:0] cur_conds;
  logic [7:0]  cur_exc;

  pred_elem_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .vl_in(vl_in),
    .pred_mask(pred_mask), .pred_all(pred_all), .pred_inv(pred_inv),
    .mode(mode), .rc(rc), .is_ldst(is_ldst), .fb_valid(fb_valid),
    .fb_cond(fb_cond), .fb_exc(fb_exc), .busy(busy), .issue(issue),
    .zero_wr(zero_wr), .commit(commit), .cr_wr(cr_wr),
    .elem_idx(elem_idx), .done(done), .trap(trap), .final_vl(final_vl)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WDOG_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sample at this falling edge, then answer an issue strobe
  task automatic observe();
    if (issue) begin
      if (elem_idx < 8) got_iss[elem_idx[2:0]] = 1'b1;
      iss_cnt  = iss_cnt + 1;
      last_iss = int'(elem_idx);
    end
    if (zero_wr && elem_idx < 8) got_zero[elem_idx[2:0]] = 1'b1;
    if (commit && elem_idx < 8)  got_com[elem_idx[2:0]]  = 1'b1;
    if (cr_wr && elem_idx < 8)   got_cr[elem_idx[2:0]]   = 1'b1;
    if (done) begin
      got_vl   = final_vl;
      got_trap = trap;
    end
    fb_valid = issue;
    fb_cond  = (elem_idx < 8) ? cur_conds[elem_idx[2:0]*4 +: 4] : 4'h0;
    fb_exc   = issue && (elem_idx < 8) && cur_exc[elem_idx[2:0]];
  endtask

  task automatic run(input logic [6:0] v, input logic [63:0] m, input logic a,
                     input logic iv, input logic [4:0] md, input logic r,
                     input logic ld, input logic [31:0] cs, input logic [7:0] ex);
    got_iss = '0; got_zero = '0; got_com = '0; got_cr = '0;
    got_vl = '1; got_trap = 1'b0; iss_cnt = 0; last_iss = -1;
    cur_conds = cs; cur_exc = ex;
    @(negedge clk);
    vl_in = v; pred_mask = m; pred_all = a; pred_inv = iv;
    mode = md; rc = r; is_ldst = ld; start = 1'b1;
    fb_valid = 1'b0; fb_exc = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 400; i++) begin
      observe();
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
    observe();
    chk("R10 done pulse ends", {63'd0, done}, 64'd0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; vl_in = '0; pred_mask = '0; pred_all = 1'b0;
    pred_inv = 1'b0; mode = '0; rc = 1'b0; is_ldst = 1'b0;
    fb_valid = 1'b0; fb_cond = '0; fb_exc = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {57'd0, busy, issue, zero_wr, commit, cr_wr, done, trap}, 64'd0);
    chk("R1 final_vl", {57'd0, final_vl}, 64'd0);

    for (int k = 0; k < NV; k++) begin
      vec_t t;
      string tag;
      t = VECS[k];
      tag = $sformatf("R%0d vec%0d", t.req, k);
      run(t.vl, {56'd0, t.mask}, t.all, t.inv, t.mode, t.rc, t.ldst, t.conds, t.exc);
      chk({tag, " issue"},    {56'd0, got_iss},  {56'd0, t.e_iss});
      chk({tag, " zero_wr"},  {56'd0, got_zero}, {56'd0, t.e_zero});
      chk({tag, " commit"},   {56'd0, got_com},  {56'd0, t.e_com});
      chk({tag, " cr_wr"},    {56'd0, got_cr},   {56'd0, t.e_cr});
      chk({tag, " final_vl"}, {57'd0, got_vl},   {57'd0, t.e_vl});
      chk({tag, " trap"},     {63'd0, got_trap}, {63'd0, t.e_trap});
    end

    // R11 exact timing of done for VL=0
    @(negedge clk);
    vl_in = 7'd0; pred_all = 1'b1; mode = '0; rc = 1'b0; is_ldst = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 done not yet", {63'd0, done}, 64'd0);
    @(negedge clk);
    chk("R11 done in second cycle", {63'd0, done}, 64'd1);
    chk("R11 final_vl zero", {57'd0, final_vl}, 64'd0);

    // R13 start ignored while busy
    got_iss = '0; got_vl = '1; cur_conds = '0; cur_exc = '0; iss_cnt = 0;
    @(negedge clk);
    vl_in = 7'd4; pred_all = 1'b1; start = 1'b1;
    @(negedge clk);
    vl_in = 7'd1; pred_all = 1'b0; pred_mask = '0;
    for (int i = 0; i < 100; i++) begin
      observe();
      if (done) break;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R13 busy run issues", {56'd0, got_iss}, 64'h0F);
    chk("R13 busy run final_vl", {57'd0, got_vl}, 64'd4);

    // R13 VL above the maximum is clamped; R3 top element only
    run(7'd100, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0, 32'h0, 8'h00);
    chk("R13 clamp final_vl", {57'd0, got_vl}, 64'd64);
    chk("R3 top element only", iss_cnt, 64'd1);
    chk("R2 top element index", last_iss, 64'd63);

    // R4 zeroing across full length: 63 zero strobes, element 0 issued
    run(7'd64, 64'd1, 1'b0, 1'b0, 5'b00101, 1'b0, 1'b0, 32'h0, 8'h00);
    chk("R4 zero low byte", {56'd0, got_zero}, 64'hFE);
    chk("R4 single issue", iss_cnt, 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule